// File: doc/BRIEF.md
# Stochastic Spiking Neuron with Probabilistic Output Steering

This block is a single digital neuron for a network of randomly firing units. Excitatory and inhibitory spike pulses arrive on two inputs and move a saturating potential counter up or down. While that counter holds a value above zero, the neuron fires at random moments. A fixed per-cycle firing probability, set by a programmable rate register, gives geometric gaps between spikes. These gaps are the discrete-time form of exponential inter-spike intervals. Every firing removes one unit of potential.

Each spike leaves on exactly one of `N_OUT` output lines for a single clock cycle. The line is picked by comparing a second random value against a set of programmable cumulative thresholds. The rate and the thresholds sit in small registers that can be rewritten through a simple write port while the neuron keeps running. The output lines are ordinary single-cycle pulses. They can drive the spike inputs of other neurons directly, so arrays of these units can be chained into any topology.

Two independent maximal-length Galois LFSRs supply the randomness. Both are loaded with fixed nonzero seeds at reset and advance every cycle.

Top module: `stoch_neuron`

## Requirements
- R1: After reset the potential reads 0, `spike_o` and `line_o` are 0, the rate setting is 0 so no firing occurs, and every cumulative threshold is all-ones so spikes go to line 0.
- R2: A cycle with `exc_i` high and no firing adds one to the potential. A cycle with `inh_i` high subtracts one, but the potential never goes below 0. With both high and no firing, the potential is unchanged.
- R3: The potential saturates at 2^POT_W-1 and never wraps to a smaller value when more excitatory pulses arrive.
- R4: With the potential at 0, no spike is produced in the following cycle, whatever the rate setting.
- R5: A firing decision is taken in a cycle when the potential is above 0 and the firing random value is less than or equal to the rate setting. A rate of 0 therefore never fires, and a rate of all-ones fires every cycle while the potential is above 0. Each firing lowers the potential by one. The spike appears on `spike_o`/`line_o` in the cycle after the decision, that is, at the same clock edge as the decrement.
- R6: When arrivals and a firing fall in the same cycle, their effects add up and the result is clamped to [0, 2^POT_W-1]. Excitation plus firing leaves the potential unchanged. Inhibition plus firing at potential 1 gives 0.
- R7: `spike_o` high comes with exactly one `line_o` bit high for that cycle. When `spike_o` is low, `line_o` is all zeros.
- R8: Address 0 of the write port holds the rate. Address k+1 holds cumulative threshold C_k for k = 0..N_OUT-2. A spike leaves on line k (bit k of `line_o`) for the smallest k with route random value <= C_k. If there is no such k, it leaves on line N_OUT-1.
- R9: A configuration write is stored at the clock edge that ends the write cycle. The decision made in the write cycle still uses the old settings, and decisions from the next cycle on use the new ones. The neuron keeps running across writes.
- R10: With the potential held above 0, the long-run spike frequency follows rate/2^RAND_W. The share of spikes on line 0 likewise follows C_0/2^RAND_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_i | input | 1 | Excitatory spike pulse, one per cycle at most |
| inh_i | input | 1 | Inhibitory spike pulse, one per cycle at most |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | CFG_AW | Configuration address: 0 rate, k+1 threshold C_k |
| cfg_data_i | input | RAND_W | Configuration write data |
| spike_o | output | 1 | High for one cycle per firing |
| line_o | output | N_OUT | One-hot routed spike, one bit per output line |
| potential_o | output | POT_W | Current potential count |

## Verification
The potential path is driven from a table of excitatory, inhibitory and combined pulses with firing disabled. This separates correct increment, decrement and floor behaviour from an update that wraps or ignores one input. A long run of excitation then tells saturation apart from wrap-around. With the rate at all-ones, firing is deterministic. Short drains from small potentials show the one-cycle decision latency, the firing-plus-arrival combinations and the zero-potential block. Threshold settings of all-zeros, all-ones and mixed values force each output line in turn, and a mid-run threshold write shows the exact cycle at which steering changes. Runs of two thousand cycles with the rate and C_0 at half scale check that the firing and steering frequencies follow the programmed probabilities rather than sitting stuck at zero or one.

// File: rtl/sn_pkg.sv
// Package: shared helpers for the stochastic neuron.
// Provides the Galois feedback masks of maximal-length LFSRs for the
// supported random widths. Assumes callers use one of 8, 16, 24 or 32.
package sn_pkg;

    // Return the right-shift Galois feedback mask for a maximal-length LFSR.
    function automatic logic [63:0] galois_taps(input int width);
        case (width)
            8:       galois_taps = 64'h0000_0000_0000_00B8;
            16:      galois_taps = 64'h0000_0000_0000_B400;
            24:      galois_taps = 64'h0000_0000_00E1_0000;
            32:      galois_taps = 64'h0000_0000_A300_0000;
            default: galois_taps = 64'h0000_0000_0000_B400;
        endcase
    endfunction

endpackage

// File: rtl/sn_lfsr.sv
// Module: sn_lfsr
// Free-running Galois LFSR, advancing one step per clock.
// Assumes SEED is nonzero and W is a width the package knows a
// maximal-length mask for; the state then never reaches zero.
module sn_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] SEED = 'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value_o
);
    localparam logic [W-1:0] TAPS = W'(sn_pkg::galois_taps(W));

    logic [W-1:0] state_q;
    logic [W-1:0] state_d;

    // Next state: shift right, fold the feedback mask in when bit 0 is set.
    always_comb begin
        state_d = {1'b0, state_q[W-1:1]};
        if (state_q[0]) begin
            state_d = state_d ^ TAPS;
        end
    end

    // State register, loaded with the seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else begin
            state_q <= state_d;
        end
    end

    assign value_o = state_q;

endmodule

// File: rtl/sn_potential.sv
// Module: sn_potential
// Saturating potential counter. One excitatory step up, one inhibitory
// step down and one firing step down may all occur in the same cycle;
// their net effect is applied and clamped to [0, 2^POT_W-1].
// Assumes fire_i is only raised while the count is nonzero.
module sn_potential #(
    parameter int POT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    input  logic             fire_i,
    output logic [POT_W-1:0] count_o
);
    localparam int               EXT_W   = POT_W + 1;
    localparam logic [EXT_W-1:0] POT_MAX = EXT_W'((1 << POT_W) - 1);

    logic [POT_W-1:0] count_q;
    logic [POT_W-1:0] count_d;
    logic [EXT_W-1:0] raised;
    logic [EXT_W-1:0] lowered;
    logic [1:0]       drop;

    // Combine this cycle's arrivals and firing, then clamp both ends.
    always_comb begin
        drop    = 2'(dec_i) + 2'(fire_i);
        raised  = {1'b0, count_q} + EXT_W'(inc_i);
        lowered = '0;
        if (raised < EXT_W'(drop)) begin
            count_d = '0;
        end else begin
            lowered = raised - EXT_W'(drop);
            if (lowered > POT_MAX) begin
                count_d = POT_MAX[POT_W-1:0];
            end else begin
                count_d = lowered[POT_W-1:0];
            end
        end
    end

    // Potential register, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/sn_cfg_regs.sv
// Module: sn_cfg_regs
// Holds the firing rate and the N_OUT-1 cumulative routing thresholds.
// Address 0 selects the rate, address k+1 selects threshold C_k.
// Writes land at the clock edge and are visible from the next cycle.
// Assumes N_OUT >= 2.
module sn_cfg_regs #(
    parameter int N_OUT  = 4,
    parameter int RAND_W = 16,
    parameter int CFG_AW = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we_i,
    input  logic [CFG_AW-1:0]                addr_i,
    input  logic [RAND_W-1:0]                data_i,
    output logic [RAND_W-1:0]                rate_o,
    output logic [N_OUT-2:0][RAND_W-1:0]     cum_o
);
    logic [RAND_W-1:0] rate_q;

    // Rate register: zero on reset so nothing fires until programmed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= '0;
        end else if (we_i && (addr_i == '0)) begin
            rate_q <= data_i;
        end
    end

    assign rate_o = rate_q;

    // One threshold register per selectable boundary between lines.
    for (genvar k = 0; k < N_OUT - 1; k++) begin : g_cum
        logic [RAND_W-1:0] cum_q;

        // Threshold C_k: all-ones on reset so every spike takes line 0.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cum_q <= '1;
            end else if (we_i && (addr_i == CFG_AW'(k + 1))) begin
                cum_q <= data_i;
            end
        end

        assign cum_o[k] = cum_q;
    end

endmodule

// File: rtl/sn_router.sv
// Module: sn_router
// Picks the output line for a spike: line k is taken for the smallest k
// whose cumulative threshold is at or above the random value, the last
// line otherwise. The choice is registered as a one-cycle one-hot pulse.
// Assumes thresholds are meant to be non-decreasing; if not, the lowest
// matching line still wins, so the result stays one-hot.
module sn_router #(
    parameter int N_OUT  = 4,
    parameter int RAND_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fire_i,
    input  logic [RAND_W-1:0]            rand_i,
    input  logic [N_OUT-2:0][RAND_W-1:0] cum_i,
    output logic [N_OUT-1:0]             line_o
);
    logic [N_OUT-1:0] hit;
    logic [N_OUT-1:0] pick;
    logic [N_OUT-1:0] line_q;

    // Compare the random value against each boundary; last line always hits.
    for (genvar k = 0; k < N_OUT - 1; k++) begin : g_cmp
        assign hit[k] = (rand_i <= cum_i[k]);
    end
    assign hit[N_OUT-1] = 1'b1;

    // Keep only the lowest hit, isolated with a two's-complement mask.
    always_comb begin
        pick = hit & (~hit + N_OUT'(1));
    end

    // Output register: one-hot for one cycle when firing, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (fire_i) begin
            line_q <= pick;
        end else begin
            line_q <= '0;
        end
    end

    assign line_o = line_q;

endmodule

// File: rtl/stoch_neuron.sv
// Module: stoch_neuron (top)
// One stochastic spiking neuron. Arrivals move a saturating potential;
// while it is above zero the neuron fires when a random value does not
// exceed the programmed rate, and each spike is steered to one output
// line chosen by a second random value and cumulative thresholds.
// Assumes exc_i/inh_i are single-cycle pulses synchronous to clk.
module stoch_neuron #(
    parameter int                N_OUT      = 4,
    parameter int                POT_W      = 8,
    parameter int                RAND_W     = 16,
    parameter logic [RAND_W-1:0] FIRE_SEED  = 'hACE1,
    parameter logic [RAND_W-1:0] ROUTE_SEED = 'h5A3C,
    localparam int               CFG_AW     = (N_OUT > 2) ? $clog2(N_OUT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_i,
    input  logic              inh_i,
    input  logic              cfg_we_i,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic [RAND_W-1:0] cfg_data_i,
    output logic              spike_o,
    output logic [N_OUT-1:0]  line_o,
    output logic [POT_W-1:0]  potential_o
);
    logic [RAND_W-1:0]            fire_rand;
    logic [RAND_W-1:0]            route_rand;
    logic [RAND_W-1:0]            rate;
    logic [N_OUT-2:0][RAND_W-1:0] cum;
    logic [POT_W-1:0]             pot;
    logic                         fire_now;
    logic                         spike_q;

    sn_lfsr #(.W(RAND_W), .SEED(FIRE_SEED)) i_fire_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .value_o (fire_rand)
    );

    sn_lfsr #(.W(RAND_W), .SEED(ROUTE_SEED)) i_route_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .value_o (route_rand)
    );

    sn_cfg_regs #(.N_OUT(N_OUT), .RAND_W(RAND_W), .CFG_AW(CFG_AW)) i_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (cfg_we_i),
        .addr_i (cfg_addr_i),
        .data_i (cfg_data_i),
        .rate_o (rate),
        .cum_o  (cum)
    );

    // Firing decision: potential strictly positive and random within rate.
    always_comb begin
        fire_now = (pot != '0) && (fire_rand <= rate);
    end

    sn_potential #(.POT_W(POT_W)) i_pot (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (exc_i),
        .dec_i   (inh_i),
        .fire_i  (fire_now),
        .count_o (pot)
    );

    sn_router #(.N_OUT(N_OUT), .RAND_W(RAND_W)) i_router (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire_now),
        .rand_i (route_rand),
        .cum_i  (cum),
        .line_o (line_o)
    );

    // Spike flag register, aligned with the routed line pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spike_q <= 1'b0;
        end else begin
            spike_q <= fire_now;
        end
    end

    assign spike_o     = spike_q;
    assign potential_o = pot;

endmodule

// File: rtl/sn_checker.sv
// Module: sn_checker
// Property checks on the neuron's ports, attached to every instance of
// the top by the bind below. Assumes reset is held low from time zero.
module sn_checker #(
    parameter int N_OUT = 4,
    parameter int POT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             exc_i,
    input logic             spike_o,
    input logic [N_OUT-1:0] line_o,
    input logic [POT_W-1:0] potential_o
);
    AST_LINE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(line_o)); // R7
    AST_SPIKE_HAS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        spike_o |-> ($countones(line_o) == 1)); // R7
    AST_QUIET_NO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !spike_o |-> (line_o == '0)); // R7
    AST_NO_FIRE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (potential_o == '0) |=> !spike_o); // R4
    AST_SPIKE_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_i |=> (!spike_o || (potential_o < $past(potential_o)))); // R5
    AST_NO_RISE_WITHOUT_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_i |=> (potential_o <= $past(potential_o))); // R2
endmodule

bind stoch_neuron sn_checker #(.N_OUT(N_OUT), .POT_W(POT_W)) i_sn_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_i       (exc_i),
    .spike_o     (spike_o),
    .line_o      (line_o),
    .potential_o (potential_o)
);

// File: tb/test_stoch_neuron.sv
module test_stoch_neuron;
    localparam int N_OUT  = 4;
    localparam int POT_W  = 8;
    localparam int RAND_W = 16;
    localparam int CFG_AW = 2;
    localparam int POT_MAX = (1 << POT_W) - 1;
    localparam logic [RAND_W-1:0] ALL1 = '1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              exc = 1'b0;
    logic              inh = 1'b0;
    logic              we = 1'b0;
    logic [CFG_AW-1:0] addr = '0;
    logic [RAND_W-1:0] wdata = '0;
    logic              spike;
    logic [N_OUT-1:0]  line;
    logic [POT_W-1:0]  pot;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    stoch_neuron #(.N_OUT(N_OUT), .POT_W(POT_W), .RAND_W(RAND_W)) i_stoch_neuron (
        .clk(clk), .rst_n(rst_n), .exc_i(exc), .inh_i(inh),
        .cfg_we_i(we), .cfg_addr_i(addr), .cfg_data_i(wdata),
        .spike_o(spike), .line_o(line), .potential_o(pot)
    );

    // Potential table, firing disabled: {exc, inh, expected potential after}.
    localparam logic [9:0] POT_VEC [12] = '{
        {1'b1, 1'b0, 8'd1}, {1'b1, 1'b0, 8'd2}, {1'b1, 1'b0, 8'd3},
        {1'b0, 1'b1, 8'd2}, {1'b1, 1'b1, 8'd2}, {1'b0, 1'b0, 8'd2},
        {1'b0, 1'b1, 8'd1}, {1'b0, 1'b1, 8'd0}, {1'b0, 1'b1, 8'd0},
        {1'b1, 1'b1, 8'd0}, {1'b1, 1'b0, 8'd1}, {1'b0, 1'b1, 8'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    // Drive pulses at a falling edge, return at the next falling edge.
    task automatic step(input logic e, input logic i);
        exc = e;
        inh = i;
        @(negedge clk);
    endtask

    task automatic cfg_write(input int a, input logic [RAND_W-1:0] d);
        we = 1'b1;
        addr = CFG_AW'(a);
        wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    // Route check: raise potential to 2, program thresholds, fire, observe.
    task automatic route_case(input logic [RAND_W-1:0] c0, input logic [RAND_W-1:0] c1,
                              input logic [RAND_W-1:0] c2, input int exp_line);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        cfg_write(1, c0);
        cfg_write(2, c1);
        cfg_write(3, c2);
        cfg_write(0, ALL1);
        step(1'b0, 1'b0);
        check("R8 route line first spike", int'(line), 1 << exp_line);
        step(1'b0, 1'b0);
        check("R8 route line second spike", int'(line), 1 << exp_line);
        step(1'b0, 1'b0);
        check("R4 drained potential", int'(pot), 0);
        cfg_write(0, '0);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: reset state held
        check("R1 potential at reset", int'(pot), 0);
        check("R1 spike at reset", int'(spike), 0);
        check("R1 lines at reset", int'(line), 0);
        rst_n = 1'b1;

        // R2: table walk with the reset rate of 0 (R1: no firing)
        foreach (POT_VEC[n]) begin
            step(POT_VEC[n][9], POT_VEC[n][8]);
            check("R2 potential table", int'(pot), int'(POT_VEC[n][7:0]));
            check("R1 no spike at reset rate", int'(spike), 0);
        end

        // R3: saturation under a long excitatory run
        for (int n = 0; n < POT_MAX + 5; n++) step(1'b1, 1'b0);
        check("R3 saturated potential", int'(pot), POT_MAX);
        step(1'b1, 1'b0);
        check("R3 no wrap", int'(pot), POT_MAX);
        for (int n = 0; n < POT_MAX + 2; n++) step(1'b0, 1'b1);
        check("R2 floor after drain", int'(pot), 0);

        // R5/R9: build potential 3, enable always-fire rate, watch drain
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        cfg_write(0, ALL1);
        check("R9 old rate in write cycle (potential)", int'(pot), 3);
        check("R9 old rate in write cycle (spike)", int'(spike), 0);
        step(1'b0, 1'b0);
        check("R5 first spike", int'(spike), 1);
        check("R5 decrement 3->2", int'(pot), 2);
        check("R1 default route line 0", int'(line), 1);
        step(1'b0, 1'b0);
        check("R5 decrement 2->1", int'(pot), 1);
        step(1'b0, 1'b0);
        check("R5 decrement 1->0", int'(pot), 0);
        check("R5 spike at last unit", int'(spike), 1);
        step(1'b0, 1'b0);
        check("R4 no spike from zero", int'(spike), 0);
        check("R7 lines idle without spike", int'(line), 0);

        // R6: arrivals combined with firing
        step(1'b1, 1'b0);
        check("R6 arrival at zero", int'(pot), 1);
        check("R4 no spike decided at zero", int'(spike), 0);
        step(1'b1, 1'b0);
        check("R6 exc plus fire unchanged", int'(pot), 1);
        check("R6 spike with exc", int'(spike), 1);
        step(1'b0, 1'b1);
        check("R6 inh plus fire clamps", int'(pot), 0);
        check("R6 spike with inh", int'(spike), 1);
        step(1'b0, 1'b0);
        check("R4 quiet at zero", int'(spike), 0);
        cfg_write(0, '0);

        // R8: force each line through the thresholds
        route_case(ALL1, ALL1, ALL1, 0);
        route_case('0, ALL1, ALL1, 1);
        route_case('0, '0, ALL1, 2);
        route_case('0, '0, '0, 3);

        // R9: mid-run threshold write while firing continuously
        cfg_write(1, ALL1);
        cfg_write(2, ALL1);
        cfg_write(3, ALL1);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        exc = 1'b1;
        cfg_write(0, ALL1);
        @(negedge clk);
        check("R9 running on line 0", int'(line), 1);
        cfg_write(1, '0);
        check("R9 write cycle keeps old line", int'(line), 1);
        @(negedge clk);
        check("R9 new line after write", int'(line), 2);
        cfg_write(1, ALL1);

        // R10: firing frequency at half rate, potential held up by exc
        for (int n = 0; n < 20; n++) @(negedge clk);
        cfg_write(0, 16'h7FFF);
        begin
            int fires = 0;
            int bad = 0;
            for (int n = 0; n < 2000; n++) begin
                @(negedge clk);
                fires += int'(spike);
                if ($countones(line) != int'(spike)) bad++;
            end
            check_range("R10 spike count at half rate", fires, 800, 1200);
            check("R7 one line per spike", bad, 0);
        end

        // R10: steering share with C_0 at half scale, always firing
        cfg_write(1, 16'h7FFF);
        cfg_write(0, ALL1);
        begin
            int l0 = 0;
            int l1 = 0;
            for (int n = 0; n < 2000; n++) begin
                @(negedge clk);
                l0 += int'(line[0]);
                l1 += int'(line[1]);
            end
            check_range("R10 line 0 share", l0, 800, 1200);
            check("R8 lines 0 and 1 cover all spikes", l0 + l1, 2000);
        end
        exc = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1..R10 run actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule